// File: doc/BRIEF.md
# Two-Source Interrupt Arbiter with Fixed Vectors

This block decides when a small 4-bit controller core leaves its instruction stream to service an interrupt. It watches two external interrupt pins and a request line from the timer. It keeps a global interrupt enable and one blocking flag per external pin. When an interrupt is taken it raises a single-cycle `take` pulse. The sequencer uses that pulse to push the return address and to load the program counter from `vector`. The same cycle carries the number of the source being served.

A single request latch serves both external pins, and it also records which pin fired. A rising edge on a pin whose blocking flag is clear sets that latch and sets the pin's flag. While a flag is set, edges on that pin are dropped. The decoder sets and clears the enable and the flags through single-cycle strobes. The sequencer also reports when the previous instruction was a page prefix (opcode bits `op & 0x3E0 == 0x340`). No interrupt may split that prefix from the jump it qualifies.

Top module: `irq_arbiter`

## Requirements
- R1: Reset clears the global enable and both pending requests, and sets both external blocking flags. Right after reset, an edge on either pin gives no `take`, even once the enable is set.
- R2: A pin can only raise an external request on a rising edge, seen one clock after the pin goes high. Holding a pin high or lowering it raises nothing.
- R3: An accepted rising edge sets that pin's blocking flag. Later edges on that pin are ignored until the decoder clears the flag.
- R4: `take` is 1 only while the enable is set and an external or timer request is pending. It is combinational on that state in the same cycle.
- R5: `take` stays 0 in every cycle in which `prev_prefix` is 1, whatever the state is.
- R6: The clock edge that ends a `take` cycle clears the global enable, so `take` is never high in two consecutive cycles.
- R7: An external request beats a timer request. External service gives `vector` = 0x7F and `src` = the pin number (0 or 1). Timer service gives `vector` = 0x3F and `src` = 2.
- R8: Only the request that was served is cleared. A timer request that lost to an external one stays pending and is taken once the enable is set again.
- R9: The enable and flag set/clear strobes take effect at the next clock edge, not in the cycle in which they are driven.
- R10: `tmr_ack` pulses together with `take` exactly when the timer request is the one being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | 2 | External interrupt pins, bit i is line i |
| tmr_req | input | 1 | Timer overflow request pulse |
| en_set | input | 1 | Set global interrupt enable |
| en_clr | input | 1 | Clear global interrupt enable |
| flag_set | input | 2 | Set blocking flag of line i |
| flag_clr | input | 2 | Clear blocking flag of line i |
| prev_prefix | input | 1 | Previous instruction was a page prefix |
| take | output | 1 | Take interrupt this cycle |
| vector | output | VEC_W | Target address of the interrupt |
| src | output | 2 | Source served: 0, 1 external, 2 timer |
| tmr_ack | output | 1 | Timer request is being served |

## Verification
Every strobe, pin edge and timer pulse is stored at the first rising clock edge after it is driven. Its effect on `take`, `vector`, `src` and `tmr_ack` is therefore due one cycle later. In contrast, `prev_prefix` acts on `take` within the same cycle. The bench drives inputs on the falling edge and checks outputs on the next falling edge, one full cycle later. The R5 and R9 cases differ: they check within the same half-cycle, a short delay after driving the input, to show that the prefix acts at once and that a strobe does not.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int            VEC_W   = 7,
  parameter logic [VEC_W-1:0] EXT_VEC = 7'h7F,
  parameter logic [VEC_W-1:0] TMR_VEC = 7'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       irq_pin,
  input  logic             tmr_req,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic [1:0]       flag_set,
  input  logic [1:0]       flag_clr,
  input  logic             prev_prefix,
  output logic             take,
  output logic [VEC_W-1:0] vector,
  output logic [1:0]       src,
  output logic             tmr_ack
);
  localparam logic [1:0] SRC_TMR = 2'd2;

  logic [1:0] pin_q, blk, rise, accept;
  logic       ie, ext_pend, ext_line, tmr_pend;
  logic       take_ext, take_tmr;

  assign rise     = irq_pin & ~pin_q;
  assign accept   = rise & ~blk;
  assign take     = ie & (ext_pend | tmr_pend) & ~prev_prefix;
  assign take_ext = take & ext_pend;
  assign take_tmr = take & ~ext_pend;
  assign vector   = ext_pend ? EXT_VEC : TMR_VEC;
  assign src      = ext_pend ? {1'b0, ext_line} : SRC_TMR;
  assign tmr_ack  = take_tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q    <= '0;
      blk      <= 2'b11;
      ie       <= 1'b0;
      ext_pend <= 1'b0;
      ext_line <= 1'b0;
      tmr_pend <= 1'b0;
    end else begin
      pin_q <= irq_pin;
      for (int i = 0; i < 2; i++)
        blk[i] <= accept[i] | flag_set[i] | (blk[i] & ~flag_clr[i]);
      ext_pend <= (|accept) | (ext_pend & ~take_ext);
      if (|accept) ext_line <= ~accept[0];
      tmr_pend <= tmr_req | (tmr_pend & ~take_tmr);
      ie       <= ~take & (en_set | (ie & ~en_clr));
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int VEC_W = 7,
  parameter logic [VEC_W-1:0] EXT_VEC = 7'h7F,
  parameter logic [VEC_W-1:0] TMR_VEC = 7'h3F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prev_prefix,
  input logic             take,
  input logic [VEC_W-1:0] vector,
  input logic [1:0]       src,
  input logic             tmr_ack
);
  p_prefix_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prev_prefix |-> !take);
  p_single_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  p_ext_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src != 2'd2) |-> (vector == EXT_VEC && src < 2'd2));
  p_tmr_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src == 2'd2) |-> vector == TMR_VEC);
  p_ack_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ack |-> (take && src == 2'd2));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .prev_prefix(prev_prefix), .take(take),
  .vector(vector), .src(src), .tmr_ack(tmr_ack));

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] irq_pin = 0, flag_set = 0, flag_clr = 0;
  logic tmr_req = 0, en_set = 0, en_clr = 0, prev_prefix = 0;
  logic take, tmr_ack;
  logic [6:0] vector;
  logic [1:0] src;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_arbiter dut_i (.clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .tmr_req(tmr_req),
    .en_set(en_set), .en_clr(en_clr), .flag_set(flag_set), .flag_clr(flag_clr),
    .prev_prefix(prev_prefix), .take(take), .vector(vector), .src(src), .tmr_ack(tmr_ack));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tmr_req = 0; en_set = 0; en_clr = 0; flag_set = 0; flag_clr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; irq_pin = 0; prev_prefix = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic check_take(input string req, input bit exp_take, input int exp_src,
                            input int exp_vec, input bit exp_ack);
    chk(take == exp_take, req, take, exp_take);
    if (exp_take) begin
      chk(src == exp_src, req, src, exp_src);
      chk(vector == exp_vec, req, vector, exp_vec);
    end
    chk(tmr_ack == exp_ack, req, tmr_ack, exp_ack);
  endtask

  task automatic t_reset();
    do_reset();
    check_take("R1", 0, 0, 0, 0);
    tmr_req = 1; tick();
    check_take("R4", 0, 0, 0, 0);
    irq_pin = 2'b01; en_set = 1; tick();
    check_take("R7", 1, 2, 7'h3F, 1);
    tick();
    irq_pin = 2'b11; en_set = 1; tick();
    tick();
    check_take("R1", 0, 0, 0, 0);
  endtask

  task automatic t_edge();
    do_reset();
    flag_clr = 2'b11; tick();
    irq_pin = 2'b01; tick();
    check_take("R4", 0, 0, 0, 0);
    en_set = 1; tick();
    check_take("R7", 1, 0, 7'h7F, 0);
    tick();
    check_take("R6", 0, 0, 0, 0);
    flag_clr = 2'b01; en_set = 1; tick();
    tick();
    check_take("R2", 0, 0, 0, 0);
    irq_pin = 2'b00; tick(); tick();
    check_take("R2", 0, 0, 0, 0);
    irq_pin = 2'b01; tick();
    check_take("R2", 1, 0, 7'h7F, 0);
    tick();
    en_set = 1; irq_pin = 2'b00; tick();
    irq_pin = 2'b01; tick(); tick();
    check_take("R3", 0, 0, 0, 0);
    irq_pin = 2'b00; flag_clr = 2'b01; tick();
    irq_pin = 2'b01; tick();
    check_take("R3", 1, 0, 7'h7F, 0);
    tick();
  endtask

  task automatic t_line1();
    do_reset();
    flag_clr = 2'b11; en_set = 1; tick();
    irq_pin = 2'b10; tick();
    check_take("R7", 1, 1, 7'h7F, 0);
    tick();
    check_take("R6", 0, 0, 0, 0);
  endtask

  task automatic t_priority();
    do_reset();
    flag_clr = 2'b11; tick();
    irq_pin = 2'b01; tmr_req = 1; en_set = 1; tick();
    check_take("R7", 1, 0, 7'h7F, 0);
    tick();
    check_take("R8", 0, 0, 0, 0);
    en_set = 1; tick();
    check_take("R8", 1, 2, 7'h3F, 1);
    tick();
    en_set = 1; tick();
    check_take("R10", 0, 0, 0, 0);
  endtask

  task automatic t_prefix();
    do_reset();
    flag_clr = 2'b11; en_set = 1; tick();
    irq_pin = 2'b01; tick();
    prev_prefix = 1; #1;
    check_take("R5", 0, 0, 0, 0);
    tick(); #1;
    check_take("R5", 0, 0, 0, 0);
    prev_prefix = 0; #1;
    check_take("R5", 1, 0, 7'h7F, 0);
    tick();
  endtask

  task automatic t_strobe();
    do_reset();
    tmr_req = 1; en_set = 1; #1;
    check_take("R9", 0, 0, 0, 0);
    tick();
    check_take("R9", 1, 2, 7'h3F, 1);
    tick();
    en_set = 1; tick();
    en_clr = 1; tick();
    tmr_req = 1; tick();
    check_take("R9", 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_edge();
    t_line1();
    t_priority();
    t_prefix();
    t_strobe();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule